// File: doc/BRIEF.md
# Fault Entry and Return Controller

This block owns the architectural state that changes when a processor takes a fault and when it comes back from one. It holds a 64-bit control word and a 32-bit saved return address. The fault detection logic sits upstream and raises a request together with a cause code and the current program counter. It also says whether execution should resume at the faulting instruction or at the one after it, and, for a fault the program raised on purpose, an 8-bit note.

On entry, the live half of the control word moves into the saved half. The live half is rebuilt in supervisor mode with interrupts disabled, the cause recorded and the note attached. The return address is captured, and the fetch unit is told to restart at address zero. On return, the saved half drops back into the live half and the fetch unit restarts at the saved return address. The control word works as a one-deep shift store, so nesting depth is one saved level and no separate status stack exists.

The saved return address can be read or written only from supervisor mode. A user-mode attempt is refused and flagged so that the pipeline can raise a privilege fault. A return whose saved address is not word aligned is refused in the same way.

Top module: `fault_ctl`

## Requirements
- R1: After reset the live control word is all zero: mode 2'b00 (user), interrupt-disable clear, no redirect, no fault flags, and the return address read port gives zero.
- R2: One cycle after a fault request, mode_o is 2'b10 (supervisor) and irq_dis_o is 1. The live control word bit layout is [1:0] mode, [2] interrupt-disable, [15:8] cause, [23:16] note; all other bits are zero.
- R3: On entry the previous live control word moves to the saved half. On return the saved half moves back to the live half and the saved half becomes zero.
- R4: On entry the return address register captures pc_i when flt_after_i is 0, and pc_i+4 when flt_after_i is 1.
- R5: On entry the note field is loaded with flt_note_i when flt_user_i is 1, and is zero otherwise.
- R6: One cycle after a fault request, pc_redir_o is 1 and pc_tgt_o is 0.
- R7: One cycle after an accepted return, pc_redir_o is 1 and pc_tgt_o equals the return address register value before the return.
- R8: A fault request and a return request in the same cycle are handled as a fault alone.
- R9: In supervisor mode (mode 2'b10), ra_wr_i loads ra_wdata_i and ra_rd_i returns the register on ra_rdata_o in the same cycle. In any other mode the access does not touch the register, ra_rdata_o is zero, and priv_flt_o is 1 in the next cycle.
- R10: A return whose saved address has bits [1:0] not both zero is refused. align_flt_o is 1 in the next cycle, no redirect is issued and the control word is unchanged.
- R11: pc_redir_o is a single-cycle pulse; without a new request it is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flt_req_i | input | 1 | Fault entry request |
| flt_cause_i | input | 8 | Cause code for the fault |
| flt_after_i | input | 1 | 1: resume at pc_i+4, 0: resume at pc_i |
| flt_user_i | input | 1 | Fault was raised on purpose by the program |
| flt_note_i | input | 8 | Program-supplied note for such a fault |
| pc_i | input | 32 | Address of the current instruction |
| ret_req_i | input | 1 | Return-from-fault request |
| ra_wr_i | input | 1 | Write strobe for the return address register |
| ra_rd_i | input | 1 | Read strobe for the return address register |
| ra_wdata_i | input | 32 | Write data for the return address register |
| ra_rdata_o | output | 32 | Read data, zero unless a permitted read |
| ctl_o | output | 32 | Live half of the control word |
| mode_o | output | 2 | Current mode, 2'b10 supervisor |
| irq_dis_o | output | 1 | Interrupt-disable bit |
| pc_redir_o | output | 1 | Fetch redirect pulse |
| pc_tgt_o | output | 32 | Fetch redirect target |
| priv_flt_o | output | 1 | Refused user-mode access to the return address register |
| align_flt_o | output | 1 | Refused return to a misaligned address |

## Verification
The hardest state to reach is a saved half that is non-zero and differs from the live half. Only then does a return show that the right word was restored rather than cleared. The bench nests a program-raised fault inside a user context and then takes a second fault without returning. It unwinds the two levels one at a time, and later forces a simultaneous fault and return on top of a one-level stack. The refused user-mode write is made visible by a return from user mode, which exposes the unchanged register on the redirect target.

// File: rtl/fault_ctl_pkg.sv
package fault_ctl_pkg;
  localparam int unsigned HALF_W  = 32;
  localparam int unsigned CAUSE_W = 8;
  localparam int unsigned NOTE_W  = 8;
  localparam int unsigned LOW_W   = 8;
  localparam int unsigned SPARE_W = HALF_W - LOW_W - CAUSE_W - NOTE_W;

  localparam logic [1:0] MODE_USER = 2'b00;
  localparam logic [1:0] MODE_SUP  = 2'b10;

  typedef struct packed {
    logic [SPARE_W-1:0] spare;
    logic [NOTE_W-1:0]  note;
    logic [CAUSE_W-1:0] cause;
    logic [4:0]         zero;
    logic               irq_dis;
    logic [1:0]         mode;
  } ctl_word_t;
endpackage

// File: rtl/fault_ctl_word.sv
module fault_ctl_word #(
  parameter int unsigned HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enter_i,
  input  logic              leave_i,
  input  logic [HALF_W-1:0] entry_lo_i,
  output logic [HALF_W-1:0] lo_o,
  output logic [HALF_W-1:0] hi_o
);
  localparam int unsigned FULL_W = 2 * HALF_W;

  logic [FULL_W-1:0] word_q, word_d;
  logic              word_en;

  always_comb begin
    word_en = enter_i | leave_i;
    word_d  = word_q;
    if (enter_i) begin
      word_d = {word_q[HALF_W-1:0], entry_lo_i};
    end else if (leave_i) begin
      word_d = {{HALF_W{1'b0}}, word_q[FULL_W-1:HALF_W]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (word_en) begin
      word_q <= word_d;
    end
  end

  assign lo_o = word_q[HALF_W-1:0];
  assign hi_o = word_q[FULL_W-1:HALF_W];
endmodule

// File: rtl/fault_ret_addr.sv
module fault_ret_addr #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_i,
  input  logic [ADDR_W-1:0] cap_val_i,
  input  logic              sup_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] q_o,
  output logic              deny_o
);
  logic [ADDR_W-1:0] ra_q, ra_d;
  logic              ra_en;

  always_comb begin
    ra_en   = cap_i | (wr_i & sup_i);
    ra_d    = cap_i ? cap_val_i : wdata_i;
    deny_o  = (wr_i | rd_i) & ~sup_i;
    rdata_o = (rd_i & sup_i) ? ra_q : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ra_q <= '0;
    end else if (ra_en) begin
      ra_q <= ra_d;
    end
  end

  assign q_o = ra_q;
endmodule

// File: rtl/fault_ctl.sv
module fault_ctl
  import fault_ctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flt_req_i,
  input  logic [CAUSE_W-1:0] flt_cause_i,
  input  logic               flt_after_i,
  input  logic               flt_user_i,
  input  logic [NOTE_W-1:0]  flt_note_i,
  input  logic [HALF_W-1:0]  pc_i,
  input  logic               ret_req_i,
  input  logic               ra_wr_i,
  input  logic               ra_rd_i,
  input  logic [HALF_W-1:0]  ra_wdata_i,
  output logic [HALF_W-1:0]  ra_rdata_o,
  output logic [HALF_W-1:0]  ctl_o,
  output logic [1:0]         mode_o,
  output logic               irq_dis_o,
  output logic               pc_redir_o,
  output logic [HALF_W-1:0]  pc_tgt_o,
  output logic               priv_flt_o,
  output logic               align_flt_o
);
  localparam int unsigned STEP = 4;

  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  ctl_word_t         live_w, entry_w;
  logic [HALF_W-1:0] ctl_lo, ctl_hi, ra_q, cap_val;
  logic              sup, leave, misalign, deny;
  logic              redir_d, redir_q, priv_q, align_q;
  logic [HALF_W-1:0] tgt_d, tgt_q;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  always_comb begin
    live_w           = ctl_word_t'(ctl_lo);
    sup              = (live_w.mode == MODE_SUP);
    entry_w          = '0;
    entry_w.mode     = MODE_SUP;
    entry_w.irq_dis  = 1'b1;
    entry_w.cause    = flt_cause_i;
    entry_w.note     = flt_user_i ? flt_note_i : '0;
    cap_val          = pc_i + (flt_after_i ? HALF_W'(STEP) : '0);
    leave            = ret_req_i & ~flt_req_i & (ra_q[1:0] == 2'b00);
    misalign         = ret_req_i & ~flt_req_i & (ra_q[1:0] != 2'b00);
    redir_d          = flt_req_i | leave;
    tgt_d            = flt_req_i ? '0 : ra_q;
  end

  fault_ctl_word #(.HALF_W(HALF_W)) i_word (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .enter_i    (flt_req_i),
    .leave_i    (leave),
    .entry_lo_i (entry_w),
    .lo_o       (ctl_lo),
    .hi_o       (ctl_hi)
  );

  fault_ret_addr #(.ADDR_W(HALF_W)) i_ra (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cap_i     (flt_req_i),
    .cap_val_i (cap_val),
    .sup_i     (sup),
    .wr_i      (ra_wr_i),
    .rd_i      (ra_rd_i),
    .wdata_i   (ra_wdata_i),
    .rdata_o   (ra_rdata_o),
    .q_o       (ra_q),
    .deny_o    (deny)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      redir_q <= 1'b0;
      priv_q  <= 1'b0;
      align_q <= 1'b0;
    end else begin
      redir_q <= redir_d;
      priv_q  <= deny;
      align_q <= misalign;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      tgt_q <= '0;
    end else if (redir_d) begin
      tgt_q <= tgt_d;
    end
  end

  assign ctl_o       = ctl_lo;
  assign mode_o      = live_w.mode;
  assign irq_dis_o   = live_w.irq_dis;
  assign pc_redir_o  = redir_q;
  assign pc_tgt_o    = tgt_q;
  assign priv_flt_o  = priv_q;
  assign align_flt_o = align_q;
endmodule

// File: rtl/fault_ctl_chk.sv
module fault_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        flt_req,
  input logic        ret_req,
  input logic        ra_wr,
  input logic        ra_rd,
  input logic [31:0] ra_q,
  input logic [31:0] ctl_hi,
  input logic [31:0] ctl_o,
  input logic [1:0]  mode_o,
  input logic        irq_dis_o,
  input logic        pc_redir_o,
  input logic [31:0] pc_tgt_o,
  input logic [31:0] ra_rdata_o,
  input logic        priv_flt_o,
  input logic        align_flt_o
);
  a_r2_entry_state: assert property (@(posedge clk) disable iff (!rst_n)
    flt_req |=> (mode_o == 2'b10) && irq_dis_o);

  a_r3_saved_word: assert property (@(posedge clk) disable iff (!rst_n)
    flt_req |=> ctl_hi == $past(ctl_o));

  a_r6_entry_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    flt_req |=> pc_redir_o && (pc_tgt_o == 32'h0));

  a_r7_return: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && !flt_req && ra_q[1:0] == 2'b00) |=>
      pc_redir_o && (pc_tgt_o == $past(ra_q)) && (ctl_o == $past(ctl_hi)));

  a_r10_misalign: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && !flt_req && ra_q[1:0] != 2'b00) |=>
      align_flt_o && !pc_redir_o && $stable(ctl_o));

  a_r9_denied: assert property (@(posedge clk) disable iff (!rst_n)
    ((ra_wr || ra_rd) && mode_o != 2'b10) |=> priv_flt_o);

  a_r9_read_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != 2'b10) |-> (ra_rdata_o == 32'h0));

  a_r11_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (!flt_req && !ret_req) |=> !pc_redir_o);
endmodule

bind fault_ctl fault_ctl_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .flt_req     (flt_req_i),
  .ret_req     (ret_req_i),
  .ra_wr       (ra_wr_i),
  .ra_rd       (ra_rd_i),
  .ra_q        (ra_q),
  .ctl_hi      (ctl_hi),
  .ctl_o       (ctl_o),
  .mode_o      (mode_o),
  .irq_dis_o   (irq_dis_o),
  .pc_redir_o  (pc_redir_o),
  .pc_tgt_o    (pc_tgt_o),
  .ra_rdata_o  (ra_rdata_o),
  .priv_flt_o  (priv_flt_o),
  .align_flt_o (align_flt_o)
);

// File: tb/test_fault_ctl.sv
module test_fault_ctl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        flt_req, flt_after, flt_user, ret_req, ra_wr, ra_rd;
  logic [7:0]  flt_cause, flt_note;
  logic [31:0] pc, ra_wdata, ra_rdata, ctl, pc_tgt;
  logic [1:0]  mode;
  logic        irq_dis, pc_redir, priv_flt, align_flt;
  int          n_chk = 0;
  int          n_bad = 0;

  always #5 clk = ~clk;

  fault_ctl i_fault_ctl (
    .clk(clk), .rst_n(rst_n),
    .flt_req_i(flt_req), .flt_cause_i(flt_cause), .flt_after_i(flt_after),
    .flt_user_i(flt_user), .flt_note_i(flt_note), .pc_i(pc),
    .ret_req_i(ret_req), .ra_wr_i(ra_wr), .ra_rd_i(ra_rd),
    .ra_wdata_i(ra_wdata), .ra_rdata_o(ra_rdata), .ctl_o(ctl),
    .mode_o(mode), .irq_dis_o(irq_dis), .pc_redir_o(pc_redir),
    .pc_tgt_o(pc_tgt), .priv_flt_o(priv_flt), .align_flt_o(align_flt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    flt_req = 0; flt_after = 0; flt_user = 0; ret_req = 0;
    ra_wr = 0; ra_rd = 0; flt_cause = 0; flt_note = 0; pc = 0; ra_wdata = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  // live word: mode [1:0], irq_dis [2], cause [15:8], note [23:16]
  function automatic logic [31:0] sup_word(input logic [7:0] cause, input logic [7:0] note);
    return {8'h00, note, cause, 8'h06};
  endfunction

  task automatic enter(input logic [31:0] p, input logic after, input logic usr,
                       input logic [7:0] cause, input logic [7:0] note);
    flt_req = 1; pc = p; flt_after = after; flt_user = usr;
    flt_cause = cause; flt_note = note;
    step();
  endtask

  task automatic read_ra(input string req, input logic [31:0] exp);
    ra_rd = 1;
    #1 chk(req, ra_rdata, exp);
    step();
  endtask

  task automatic t_reset();
    chk("R1 mode", {30'd0, mode}, 32'h0);
    chk("R1 ctl", ctl, 32'h0);
    chk("R1 irq_dis", {31'd0, irq_dis}, 32'h0);
    chk("R1 redirect", {31'd0, pc_redir}, 32'h0);
    chk("R1 flags", {30'd0, priv_flt, align_flt}, 32'h0);
    chk("R1 rdata", ra_rdata, 32'h0);
  endtask

  task automatic t_user_fault();
    enter(32'h0000_1000, 1'b1, 1'b1, 8'h07, 8'h5A);
    chk("R6 redirect", {31'd0, pc_redir}, 32'h1);
    chk("R6 target", pc_tgt, 32'h0);
    chk("R2 mode", {30'd0, mode}, 32'h2);
    chk("R2 irq_dis", {31'd0, irq_dis}, 32'h1);
    chk("R5 note loaded", ctl, sup_word(8'h07, 8'h5A));
    chk("R11 pulse", {31'd0, pc_redir}, 32'h1);
    read_ra("R4 pc+4", 32'h0000_1004);
    chk("R11 pulse ends", {31'd0, pc_redir}, 32'h0);
  endtask

  task automatic t_nested();
    enter(32'h0000_2000, 1'b0, 1'b0, 8'h03, 8'hEE);
    chk("R5 note zero", ctl, sup_word(8'h03, 8'h00));
    read_ra("R4 pc", 32'h0000_2000);
    ret_req = 1;
    step();
    chk("R7 redirect", {31'd0, pc_redir}, 32'h1);
    chk("R7 target", pc_tgt, 32'h0000_2000);
    chk("R3 inner restore", ctl, sup_word(8'h07, 8'h5A));
    ra_wr = 1; ra_wdata = 32'h0000_3000;
    step();
    chk("R9 sup write no flag", {31'd0, priv_flt}, 32'h0);
    read_ra("R9 sup read", 32'h0000_3000);
    ret_req = 1;
    step();
    chk("R7 target 2", pc_tgt, 32'h0000_3000);
    chk("R3 outer restore", ctl, 32'h0);
    chk("R3 user mode", {30'd0, mode}, 32'h0);
  endtask

  task automatic t_user_access();
    ra_rd = 1;
    #1 chk("R9 user read zero", ra_rdata, 32'h0);
    step();
    chk("R9 read flag", {31'd0, priv_flt}, 32'h1);
    ra_wr = 1; ra_wdata = 32'h0000_4444;
    step();
    chk("R9 write flag", {31'd0, priv_flt}, 32'h1);
    ret_req = 1;
    step();
    chk("R9 write ignored", pc_tgt, 32'h0000_3000);
  endtask

  task automatic t_misalign();
    enter(32'h0000_0010, 1'b0, 1'b0, 8'h01, 8'h00);
    ra_wr = 1; ra_wdata = 32'h0000_3002;
    step();
    ret_req = 1;
    step();
    chk("R10 flag", {31'd0, align_flt}, 32'h1);
    chk("R10 no redirect", {31'd0, pc_redir}, 32'h0);
    chk("R10 ctl kept", ctl, sup_word(8'h01, 8'h00));
  endtask

  task automatic t_collide();
    flt_req = 1; ret_req = 1; pc = 32'h0000_0040; flt_after = 1; flt_cause = 8'h02;
    step();
    chk("R8 target", pc_tgt, 32'h0);
    chk("R8 ctl", ctl, sup_word(8'h02, 8'h00));
    read_ra("R8 captured", 32'h0000_0044);
    ret_req = 1;
    step();
    chk("R8 saved level", ctl, sup_word(8'h01, 8'h00));
    chk("R8 return target", pc_tgt, 32'h0000_0044);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_user_fault();
    t_nested();
    t_user_access();
    t_misalign();
    t_collide();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule